// File: doc/BRIEF.md
# Multi-Thread Performance Event Counter Unit

This unit is a small performance monitor with two 24-bit event counters. Each hardware thread drives a set of event lines. Every counter has an event code and a thread mask. On each clock cycle a counter adds the number of masked threads that assert the event line chosen by its code. For codes marked as global, the mask is ignored and the events of all threads are counted.

Software reaches the unit through a register port. It has one write channel and a separate combinational read address. Software can program the code, the mask and an interrupt enable for each counter, and it can load any value into a count. When a counter wraps past its largest value, a sticky overflow status bit is set. Software clears that bit by writing 1 to it. The interrupt output is high while an enabled status bit is set.

Top module: `perf_cnt_unit`

## Requirements
- R1: After reset every count, every configuration field, both overflow status bits and `irq_o` are zero.
- R2: For an event code with bit 7 clear, the selected line is code bits [6:0] modulo 8. Event input bit `t*8 + line` belongs to thread t. Each cycle the counter adds the number of threads t that have mask bit t set and assert that bit.
- R3: For an event code with bit 7 set, the counter adds the number of threads asserting the selected line, whatever its mask holds.
- R4: With an all-zero mask and an event code with bit 7 clear, the count does not change.
- R5: A write to a count register loads write data bits [23:0] on the next edge. It takes priority over any increment in that cycle.
- R6: Counts wrap modulo 2^24. An increment that carries past 0xFFFFFF sets that counter's overflow status bit.
- R7: Overflow status bits stay set until software writes 1 to them at the status register (bit k belongs to counter k). A wrap in the same cycle as the clear leaves the bit set.
- R8: `irq_o` is high exactly when some counter has both its status bit and its interrupt enable set.
- R9: Counter k has its count at byte address 8k and its configuration at 8k+4. The configuration word holds the event code in [7:0], the thread mask in [19:16] and the interrupt enable in [31]. Status is at 0x10. All other addresses and bits read as zero. A configuration write applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event lines, eight per thread, thread t at bits [8t+7:8t] |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Read byte address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the unit with its default parameters: two counters, four threads and eight event lines per thread. With these values a single cycle can add anywhere from zero to four to a count. The bench often preloads counts just below 0xFFFFFF, so wraps, carries of several steps and collisions between a wrap and a clear all occur in a short run. Random masks include the empty mask, and random codes cover both the global and the per-thread halves of the code space.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
    localparam int DATA_W     = 32;
    localparam int CNT_STRIDE = 8;
    localparam int CFG_OFS    = 4;
    localparam int MASK_LSB   = 16;
    localparam int IEN_BIT    = 31;
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/perf_evt_sel.sv
module perf_evt_sel #(
    parameter int NUM_THR = 4,
    parameter int NUM_EVT = 8,
    parameter int SEL_W   = 8,
    parameter int INC_W   = 3
) (
    input  logic [NUM_THR*NUM_EVT-1:0] evt_i,
    input  logic [SEL_W-1:0]           sel_i,
    input  logic [NUM_THR-1:0]         mask_i,
    output logic [INC_W-1:0]           inc_o
);
    // top code bit marks an event counted across all threads
    logic glob;
    int   line;

    always_comb begin
        glob  = sel_i[SEL_W-1];
        line  = int'(sel_i[SEL_W-2:0]) % NUM_EVT;
        inc_o = '0;
        for (int t = 0; t < NUM_THR; t++) begin
            if (evt_i[t*NUM_EVT + line] && (glob || mask_i[t])) begin
                inc_o = inc_o + INC_W'(1);
            end
        end
    end
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
    parameter int CNT_W = 24,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W:0] sum;

    always_comb begin
        st_d   = st_q;
        sum    = {1'b0, st_q.cnt} + (CNT_W+1)'(inc_i);
        wrap_o = 1'b0;
        if (wr_i) begin
            st_d.cnt = wdata_i;
        end else begin
            st_d.cnt = sum[CNT_W-1:0];
            wrap_o   = sum[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/perf_cnt_unit.sv
module perf_cnt_unit
    import perf_cnt_pkg::*;
#(
    parameter int NUM_CNT = 2,
    parameter int CNT_W   = 24,
    parameter int NUM_THR = 4,
    parameter int NUM_EVT = 8,
    parameter int SEL_W   = 8,
    parameter int ADDR_W  = $clog2(CNT_STRIDE*(NUM_CNT+1))
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_THR*NUM_EVT-1:0] evt_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic                       irq_o
);
    localparam int INC_W = $clog2(NUM_THR+1);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(CNT_STRIDE*NUM_CNT);

    typedef struct packed {
        logic [NUM_CNT-1:0][SEL_W-1:0]   sel;
        logic [NUM_CNT-1:0][NUM_THR-1:0] mask;
        logic [NUM_CNT-1:0]              ien;
        logic [NUM_CNT-1:0]              ovf;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
    logic [NUM_CNT-1:0][INC_W-1:0] inc_amt;
    logic [NUM_CNT-1:0]            cnt_wr;
    logic [NUM_CNT-1:0]            cfg_wr;
    logic [NUM_CNT-1:0]            wrap;
    logic                          stat_wr;
    logic                          unused_wdata;

    assign unused_wdata = ^wr_data_i;
    assign stat_wr      = wr_en_i && (wr_addr_i == STAT_A);

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(k*CNT_STRIDE);
        localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(k*CNT_STRIDE + CFG_OFS);

        assign cnt_wr[k] = wr_en_i && (wr_addr_i == CNT_A);
        assign cfg_wr[k] = wr_en_i && (wr_addr_i == CFG_A);

        perf_evt_sel #(
            .NUM_THR(NUM_THR), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W), .INC_W(INC_W)
        ) sel_i (
            .evt_i (evt_i),
            .sel_i (r_q.sel[k]),
            .mask_i(r_q.mask[k]),
            .inc_o (inc_amt[k])
        );

        perf_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) cnt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (cnt_wr[k]),
            .wdata_i(wr_data_i[CNT_W-1:0]),
            .inc_i  (inc_amt[k]),
            .cnt_o  (cnt_val[k]),
            .wrap_o (wrap[k])
        );
    end

    // next configuration and sticky status; a wrap outranks a clear
    always_comb begin
        r_d = r_q;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (cfg_wr[k]) begin
                r_d.sel[k]  = wr_data_i[SEL_W-1:0];
                r_d.mask[k] = wr_data_i[MASK_LSB +: NUM_THR];
                r_d.ien[k]  = wr_data_i[IEN_BIT];
            end
        end
        r_d.ovf = (r_q.ovf & ~(stat_wr ? wr_data_i[NUM_CNT-1:0] : '0)) | wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (rd_addr_i == ADDR_W'(k*CNT_STRIDE)) begin
                rd_data_o[CNT_W-1:0] = cnt_val[k];
            end
            if (rd_addr_i == ADDR_W'(k*CNT_STRIDE + CFG_OFS)) begin
                rd_data_o[SEL_W-1:0]            = r_q.sel[k];
                rd_data_o[MASK_LSB +: NUM_THR]  = r_q.mask[k];
                rd_data_o[IEN_BIT]              = r_q.ien[k];
            end
        end
        if (rd_addr_i == STAT_A) begin
            rd_data_o[NUM_CNT-1:0] = r_q.ovf;
        end
    end

    assign irq_o = |(r_q.ovf & r_q.ien);
endmodule

// File: rtl/perf_cnt_chk.sv
module perf_cnt_chk #(
    parameter int NUM_CNT = 2,
    parameter int CNT_W   = 24,
    parameter int NUM_THR = 4,
    parameter int SEL_W   = 8,
    parameter int INC_W   = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_CNT-1:0]                cnt_wr,
    input logic                              stat_wr,
    input logic [31:0]                       wr_data_i,
    input logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_val,
    input logic [NUM_CNT-1:0][INC_W-1:0]     inc_amt,
    input logic [NUM_CNT-1:0][SEL_W-1:0]     sel_q,
    input logic [NUM_CNT-1:0][NUM_THR-1:0]   mask_q,
    input logic [NUM_CNT-1:0]                ovf_q,
    input logic                              irq_o
);
    localparam logic [CNT_W:0] MAX_CNT = {1'b0, {CNT_W{1'b1}}};

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
        AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_wr[k] |=> cnt_val[k] == $past(wr_data_i[CNT_W-1:0])); // R5
        AST_EMPTY_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_wr[k] && mask_q[k] == '0 && !sel_q[k][SEL_W-1]) |=> $stable(cnt_val[k])); // R4
        AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_wr[k] && (({1'b0, cnt_val[k]} + (CNT_W+1)'(inc_amt[k])) > MAX_CNT)) |=> ovf_q[k]); // R6
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[k] && !(stat_wr && wr_data_i[k])) |=> ovf_q[k]); // R7
        AST_INC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            inc_amt[k] <= INC_W'(NUM_THR)); // R3
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ovf_q != '0)); // R8
endmodule

bind perf_cnt_unit perf_cnt_chk #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .NUM_THR(NUM_THR), .SEL_W(SEL_W),
    .INC_W($clog2(NUM_THR+1))
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_wr   (cnt_wr),
    .stat_wr  (stat_wr),
    .wr_data_i(wr_data_i),
    .cnt_val  (cnt_val),
    .inc_amt  (inc_amt),
    .sel_q    (r_q.sel),
    .mask_q   (r_q.mask),
    .ovf_q    (r_q.ovf),
    .irq_o    (irq_o)
);

// File: tb/perf_cnt_unit_tb_top.sv
module perf_cnt_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic        we = 1'b0;
    logic [4:0]  waddr = '0;
    logic [31:0] wdata = '0;
    logic [4:0]  raddr = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    logic [23:0] m_cnt [2];
    logic [7:0]  m_sel [2];
    logic [3:0]  m_mask[2];
    logic        m_ien [2];
    logic [1:0]  m_ovf;

    always #10 clk = ~clk;

    perf_cnt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(we), .wr_addr_i(waddr),
        .wr_data_i(wdata), .rd_addr_i(raddr), .rd_data_o(rdata), .irq_o(irq)
    );

    function automatic int exp_inc(logic [31:0] e, logic [7:0] sel, logic [3:0] mask);
        int n = 0;
        int line = int'(sel[6:0]) % 8;
        for (int t = 0; t < 4; t++)
            if (e[t*8 + line] && (sel[7] || mask[t])) n++;
        return n;
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        case (a)
            0:  return {8'h0, m_cnt[0]};
            4:  return {m_ien[0], 11'h0, m_mask[0], 8'h0, m_sel[0]};
            8:  return {8'h0, m_cnt[1]};
            12: return {m_ien[1], 11'h0, m_mask[1], 8'h0, m_sel[1]};
            16: return {30'h0, m_ovf};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_cnt[k] = '0; m_sel[k] = '0; m_mask[k] = '0; m_ien[k] = 1'b0;
        end
        m_ovf = '0;
    endtask

    task automatic model_step();
        logic [1:0] wr_set = '0;
        logic [1:0] clr = '0;
        for (int k = 0; k < 2; k++) begin
            logic [24:0] s;
            s = {1'b0, m_cnt[k]} + 25'(exp_inc(evt, m_sel[k], m_mask[k]));
            if (we && waddr == 5'(8*k)) m_cnt[k] = wdata[23:0];
            else begin
                m_cnt[k] = s[23:0];
                wr_set[k] = s[24];
            end
        end
        for (int k = 0; k < 2; k++) begin
            if (we && waddr == 5'(8*k+4)) begin
                m_sel[k] = wdata[7:0]; m_mask[k] = wdata[19:16]; m_ien[k] = wdata[31];
            end
        end
        if (we && waddr == 5'd16) clr = wdata[1:0];
        m_ovf = (m_ovf & ~clr) | wr_set;
    endtask

    // called at a falling edge; walks the read address and compares
    task automatic check_all(string tag);
        int addrs[7] = '{0, 4, 8, 12, 16, 20, 2};
        for (int i = 0; i < 7; i++) begin
            raddr = 5'(addrs[i]);
            #1;
            checks++;
            if (rdata !== exp_rd(addrs[i])) begin
                fails++;
                $display("FAIL %s addr=%0h actual=%h expected=%h", tag, addrs[i], rdata, exp_rd(addrs[i]));
            end
        end
        checks++;
        if (irq !== ((m_ovf[0] & m_ien[0]) | (m_ovf[1] & m_ien[1]))) begin
            fails++;
            $display("FAIL R8 irq actual=%b expected=%b", irq,
                     (m_ovf[0] & m_ien[0]) | (m_ovf[1] & m_ien[1]));
        end
    endtask

    task automatic cycle(logic [31:0] e, logic w, logic [4:0] a, logic [31:0] d, string tag);
        evt = e; we = w; waddr = a; wdata = d;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        we = 1'b0; evt = '0;
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset state");

        // R9: configure counter 0 per-thread line 2, counter 1 global line 3
        cycle('0, 1'b1, 5'd4,  32'h0005_0002, "R9 cfg0");
        cycle('0, 1'b1, 5'd12, 32'h0000_0083, "R9 cfg1");
        // R2 and R3: all threads on lines 2 and 3
        cycle(32'h0C0C_0C0C, 1'b0, '0, '0, "R2 R3 masked and global sums");
        cycle(32'h0400_0004, 1'b0, '0, '0, "R2 partial threads");
        // R4: empty mask, per-thread code
        cycle('0, 1'b1, 5'd4, 32'h0000_0001, "R4 cfg");
        cycle(32'hFFFF_FFFF, 1'b0, '0, '0, "R4 empty mask holds");
        // R5: load wins over increment in the same cycle
        cycle('0, 1'b1, 5'd4, 32'h8000_0081, "R5 cfg global with enable");
        cycle(32'h0202_0202, 1'b1, 5'd0, 32'hAB_FFFFFE, "R5 write priority");
        // R6: multi-step carry past the top, R8 interrupt
        cycle(32'h0202_0202, 1'b0, '0, '0, "R6 wrap by four");
        cycle('0, 1'b0, '0, '0, "R7 status stays");
        cycle('0, 1'b1, 5'd16, 32'h0000_0001, "R7 write one clears");
        // R7: wrap and clear in the same cycle
        cycle('0, 1'b1, 5'd8, 32'h00FF_FFFF, "R5 preload");
        cycle(32'h0000_0008, 1'b1, 5'd16, 32'h0000_0002, "R7 set beats clear");

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] e = $urandom;
            logic w = ($urandom % 3) == 0;
            logic [4:0] a = 5'(4 * ($urandom % 5));
            logic [31:0] d = $urandom;
            if (a == 5'd0 || a == 5'd8)
                if ($urandom % 2) d = 32'h00FF_FFFF - ($urandom % 6);
            cycle(e, w, a, d, "R2 R3 R4 R5 R6 R7 R9 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule